// File: doc/BRIEF.md
# In-Service Priority Level Tracker

This block keeps one in-service flag per maskable-interrupt priority level inside a small interrupt controller. There are eight levels. Level 0 is the most urgent and level 7 the least. When the controller accepts a request, the flag for that request's level is raised. When the CPU leaves a maskable handler, the flag of the most urgent level still in service is dropped. Returns from non-maskable or exception handlers leave the flags alone.

Arbitration upstream reads two outputs. The combinational most-urgent in-service level, with its valid flag, tells it which requests may interrupt the current handler. An eligibility output answers that question directly for one candidate request. A bus read port returns the flag vector, either whole or as a single selected flag. Writes that reach the port do nothing.

Top module: `inservice_tracker`

## Requirements
- R1: After reset, `svc_vec` is 8'h00, `top_valid` is 0 and `rd_valid` is 0.
- R2: A cycle with `ack_valid`=1 sets bit `ack_level` of `svc_vec` (bit n stands for level n). The bit stays set until a maskable return clears it.
- R3: A cycle with `ret_valid`=1 and `ret_nonmask`=0 clears only the lowest-numbered set bit of `svc_vec`. Level 0 is the highest priority.
- R4: A cycle with `ret_valid`=1 and `ret_nonmask`=1 leaves `svc_vec` unchanged.
- R5: A maskable return while `svc_vec` is 8'h00 leaves it 8'h00.
- R6: When an acknowledge and a maskable return fall in the same cycle, the clear is computed on the old vector and the acknowledged bit is then set. Acknowledging the level being cleared therefore leaves that bit set.
- R7: `top_valid` is 1 exactly when `svc_vec` is nonzero. `top_level` is then the index of its lowest-numbered set bit. Both follow `svc_vec` with no delay.
- R8: `req_eligible` is 1 when `req_valid`=1 and either `top_valid`=0 or `req_level` < `top_level`. Otherwise it is 0.
- R9: `rd_en`=1 in a cycle makes `rd_valid`=1 in the next cycle. `rd_data` then holds the vector as updated by that cycle, including any acknowledge in it. With `rd_bit_mode`=1, `rd_data[0]` holds bit `rd_bit_sel` and bits 7:1 are 0.
- R10: `wr_en` and `wr_data` have no effect on `svc_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Request accepted this cycle |
| ack_level | input | 3 | Level of accepted request |
| ret_valid | input | 1 | Return from a handler |
| ret_nonmask | input | 1 | The return is from a non-maskable or exception handler |
| req_valid | input | 1 | Candidate request present |
| req_level | input | 3 | Level of candidate request |
| rd_en | input | 1 | Bus read |
| rd_bit_mode | input | 1 | 1: single-flag read, 0: whole vector |
| rd_bit_sel | input | 3 | Flag selected in single-flag read |
| wr_en | input | 1 | Bus write (ignored) |
| wr_data | input | 8 | Write data (ignored) |
| svc_vec | output | 8 | In-service flags |
| top_valid | output | 1 | Some level is in service |
| top_level | output | 3 | Most urgent level in service |
| req_eligible | output | 1 | Candidate may interrupt |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
`svc_vec` changes at the clock edge that samples an acknowledge or a return. It is compared at the falling edge that follows. `rd_data` and `rd_valid` appear at the same edge as the read they answer, and carry that cycle's update. `top_level`, `top_valid` and `req_eligible` are combinational. They are compared one nanosecond after the inputs change, against the model's state from the previous edge. A behavioural model advances once per cycle, and all these values are compared against it in every cycle.

// File: rtl/inservice_tracker.sv
module inservice_tracker #(
  parameter int LEVELS = 8,
  localparam int LW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_valid,
  input  logic [LW-1:0]     ack_level,
  input  logic              ret_valid,
  input  logic              ret_nonmask,
  input  logic              req_valid,
  input  logic [LW-1:0]     req_level,
  input  logic              rd_en,
  input  logic              rd_bit_mode,
  input  logic [LW-1:0]     rd_bit_sel,
  input  logic              wr_en,
  input  logic [LEVELS-1:0] wr_data,
  output logic [LEVELS-1:0] svc_vec,
  output logic              top_valid,
  output logic [LW-1:0]     top_level,
  output logic              req_eligible,
  output logic              rd_valid,
  output logic [LEVELS-1:0] rd_data
);

  logic [LEVELS-1:0] low_bit, set_bit, vec_nxt;
  logic              clr_en;

  assign clr_en  = ret_valid && !ret_nonmask;
  assign low_bit = svc_vec & (~svc_vec + 1'b1);
  assign set_bit = ack_valid ? (LEVELS'(1) << ack_level) : '0;
  assign vec_nxt = (svc_vec & ~(clr_en ? low_bit : '0)) | set_bit;

  always_comb begin
    top_level = '0;
    for (int i = LEVELS - 1; i >= 0; i--)
      if (svc_vec[i]) top_level = LW'(i);
  end

  assign top_valid    = |svc_vec;
  assign req_eligible = req_valid && (!top_valid || req_level < top_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_vec  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      svc_vec  <= vec_nxt;
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= rd_bit_mode ? {{(LEVELS-1){1'b0}}, vec_nxt[rd_bit_sel]} : vec_nxt;
    end
  end

  assert_ack_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> svc_vec[$past(ack_level)]);

  assert_ret_drops_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_nonmask && !ack_valid && svc_vec != '0) |=>
      ($countones(svc_vec) == $countones($past(svc_vec)) - 1));

  assert_nonmask_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_nonmask && !ack_valid) |=> $stable(svc_vec));

  assert_top_is_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (svc_vec[top_level] &&
                   ((svc_vec & ((LEVELS'(1) << top_level) - 1'b1)) == '0)));

  assert_bitread_zext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_bit_mode) |=> (rd_valid && (rd_data >> 1) == '0));

  assert_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ack_valid && !ret_valid) |=> $stable(svc_vec));

endmodule

// File: tb/inservice_tracker_tb.sv
`timescale 1ns/1ps
module inservice_tracker_tb_top;
  logic clk = 0, rst_n = 0;
  logic ack_valid = 0, ret_valid = 0, ret_nonmask = 0, req_valid = 0;
  logic rd_en = 0, rd_bit_mode = 0, wr_en = 0;
  logic [2:0] ack_level = 0, req_level = 0, rd_bit_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] svc_vec, rd_data;
  logic top_valid, req_eligible, rd_valid;
  logic [2:0] top_level;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_vec = 0, m_rd = 0;
  logic m_rdv = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  inservice_tracker dut_i (.*);

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int m_top();
    for (int i = 0; i < 8; i++) if (m_vec[i]) return i;
    return -1;
  endfunction

  task automatic idle();
    ack_valid = 0; ret_valid = 0; ret_nonmask = 0; rd_en = 0;
    rd_bit_mode = 0; wr_en = 0; req_valid = 0;
  endtask

  task automatic tick();
    int t;
    logic [7:0] nv;
    #1;
    t = m_top();
    chk({tag, "/R7 top_valid"}, {7'b0, top_valid}, {7'b0, t >= 0});
    if (t >= 0) chk({tag, "/R7 top_level"}, {5'b0, top_level}, 8'(t));
    chk({tag, "/R8 eligible"}, {7'b0, req_eligible},
        {7'b0, req_valid && (t < 0 || int'(req_level) < t)});
    @(posedge clk);
    nv = m_vec;
    if (ret_valid && !ret_nonmask)
      for (int i = 0; i < 8; i++) if (nv[i]) begin nv[i] = 0; break; end
    if (ack_valid) nv[ack_level] = 1;
    m_vec = nv;
    m_rdv = rd_en;
    if (rd_en) m_rd = rd_bit_mode ? {7'b0, nv[rd_bit_sel]} : nv;
    @(negedge clk);
    chk({tag, " svc_vec"}, svc_vec, m_vec);
    chk({tag, "/R9 rd_valid"}, {7'b0, rd_valid}, {7'b0, m_rdv});
    if (m_rdv) chk({tag, "/R9 rd_data"}, rd_data, m_rd);
    idle();
  endtask

  task automatic ack(input int l); ack_valid = 1; ack_level = 3'(l); endtask
  task automatic rd(input bit bm, input int s); rd_en = 1; rd_bit_mode = bm; rd_bit_sel = 3'(s); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 svc_vec", svc_vec, 8'h00);
    chk("R1 top_valid", {7'b0, top_valid}, 8'h00);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    rst_n = 1;
    tag = "R2"; ack(5); tick(); ack(2); tick(); ack(7); tick();
    chk("R2 levels 2,5,7 set", svc_vec, 8'hA4);
    tag = "R8"; for (int l = 0; l < 8; l++) begin req_valid = 1; req_level = 3'(l); tick(); end
    tag = "R9"; rd(0, 0); tick(); rd(1, 5); tick(); rd(1, 3); tick();
    tag = "R9"; ack(1); rd(0, 0); tick();
    chk("R9 read includes same-cycle ack", rd_data, 8'hA6);
    tag = "R10"; wr_en = 1; wr_data = 8'hFF; rd(0, 0); tick();
    chk("R10 write ignored", rd_data, 8'hA6);
    tag = "R4"; ret_valid = 1; ret_nonmask = 1; tick();
    chk("R4 nonmask return keeps vector", svc_vec, 8'hA6);
    tag = "R3"; ret_valid = 1; tick();
    chk("R3 return clears level 1", svc_vec, 8'hA4);
    tag = "R6"; ret_valid = 1; ack(2); tick();
    chk("R6 same level ack+return keeps bit", svc_vec, 8'hA4);
    tag = "R6"; ret_valid = 1; ack(0); tick();
    chk("R6 clears old lowest then sets new", svc_vec, 8'hA1);
    tag = "R3"; repeat (3) begin ret_valid = 1; tick(); end
    chk("R3 drained", svc_vec, 8'h00);
    tag = "R5"; ret_valid = 1; tick();
    chk("R5 return on empty", svc_vec, 8'h00);
    tag = "mixed";
    for (int n = 0; n < 400; n++) begin
      ack_valid = 1'($urandom_range(0, 2) == 0); ack_level = 3'($urandom);
      ret_valid = 1'($urandom_range(0, 3) == 0); ret_nonmask = 1'($urandom);
      req_valid = 1'($urandom); req_level = 3'($urandom);
      rd_en = 1'($urandom); rd_bit_mode = 1'($urandom); rd_bit_sel = 3'($urandom);
      wr_en = 1'($urandom); wr_data = 8'($urandom);
      tick();
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule